// File: doc/BRIEF.md
# Triggered Burst PWM Generator

This block produces an edge-aligned PWM waveform in bursts. It does not free-run. While idle, its period counter rests at zero and its output is low. When an accepted start event arrives, it runs a programmed number of PWM cycles, from one to eight, and then returns to idle. Each cycle lasts `period` clocks. The output is high for the first `duty` clocks of each cycle. A one-clock end-of-cycle pulse marks the last clock of every cycle.

The start event is the OR of three things:
- a software trigger;
- an optional external sync pulse, which must already be in this clock domain;
- one hardware source chosen by a 4-bit select. The select can pick the generator's own end-of-cycle, or the trigger output of one of four peer generators.

Period and duty each come from either a local value or a shared master value. A separate select bit controls each of them. The generator has two trigger modes. In single-shot mode it ignores start events during a burst. In retriggerable mode a start event extends the burst. Dropping the enable clears everything on the next clock.

Top module: `burst_pwm_gen`

## Requirements
- R1: Out of reset, and at any time the generator is idle, `running`, `pwm_out` and `eoc_pulse` are all low.
- R2: The hardware start source is decoded from `start_src` as follows. Value 0 selects the generator's own end-of-cycle. Values 1 to 4 select `peer_trig[0]` to `peer_trig[3]`. Values 5 to 15 select no hardware source. `sw_trig` can always start an idle generator. A trigger accepted at a clock edge sets `running` high from that edge.
- R3: When `sync_en` is 1, `sync_pulse` starts the generator in addition to the selected source. When `sync_en` is 0, `sync_pulse` has no effect.
- R4: With `burst_len` = N, a burst started from idle runs N+1 complete cycles. `running` stays high for exactly (N+1)×period clocks, and the burst never ends in the middle of a cycle.
- R5: Inside a cycle the count runs from 0 to period−1. `pwm_out` is high while the count is below duty. A duty of 0 gives no high clocks. A duty of period or more keeps the output high for the whole burst.
- R6: `eoc_pulse` is high for exactly one clock per cycle, on the clock where the count equals period−1. A burst of N+1 cycles gives N+1 pulses.
- R7: When `trig_mode` is 00 (and also for the reserved codes 10 and 11), start events that arrive during a burst are ignored.
- R8: When `trig_mode` is 01, an event during a burst reloads the remaining count without disturbing the cycle in progress. If the event arrives before the last clock of the cycle, that cycle counts as the first of N+1 cycles. If it arrives on the last clock, the next cycle counts as the first. With `start_src` = 0 the generator therefore runs without end.
- R9: When `use_master_per` is 1 the period comes from `master_per`, otherwise from `local_per`. When `use_master_duty` is 1 the duty comes from `master_duty`, otherwise from `local_duty`.
- R10: Period and duty are captured when each cycle starts, so a change made during a cycle first acts on the next cycle. A period of 0 is treated as 1.
- R11: While `enable` is 0, all state is cleared at each clock, so all three outputs are low on the next clock. When `enable` returns to 1, the interrupted burst does not resume.
- R12: Start events from several sources in the same clock merge into one event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Generator enable; 0 clears all state |
| trig_mode | input | 2 | 01 retriggerable, all other codes single-shot |
| burst_len | input | 3 | Cycles per burst minus one |
| start_src | input | 4 | Hardware start source select |
| sync_en | input | 1 | Allows sync_pulse to start the generator |
| use_master_per | input | 1 | Period taken from master_per |
| use_master_duty | input | 1 | Duty taken from master_duty |
| local_per | input | 16 | Local period in clocks |
| local_duty | input | 16 | Local duty in clocks |
| master_per | input | 16 | Shared master period |
| master_duty | input | 16 | Shared master duty |
| peer_trig | input | 4 | Trigger outputs of the peer generators |
| sw_trig | input | 1 | Software start pulse |
| sync_pulse | input | 1 | Synchronized external sync pulse |
| pwm_out | output | 1 | PWM waveform |
| eoc_pulse | output | 1 | One-clock end-of-cycle pulse |
| running | output | 1 | High while a burst is in progress |

## Verification
A wrong remaining-cycle count shows at the ports as a wrong length for `running` and a wrong number of `eoc_pulse` pulses, and this is visible at the end of the first burst. A wrong cycle counter or a wrong captured period shifts the end-of-cycle pulse and the duty edge inside the first cycle, within one period of the trigger. Errors in source decoding or trigger acceptance show up one clock after the trigger pulse as a `running` level that is wrong. For retriggering, the error shows as a burst whose total length is off by whole periods.

// File: rtl/burst_pwm_pkg.sv
// Package: shared types and helpers for the triggered burst PWM generator.
// Assumes nothing beyond IEEE 1800-2017.
package burst_pwm_pkg;

    // Trigger mode codes; only RETRIG changes behaviour, the rest act single-shot.
    typedef enum logic [1:0] {
        TM_SINGLE = 2'b00,
        TM_RETRIG = 2'b01,
        TM_RSVD_A = 2'b10,
        TM_RSVD_B = 2'b11
    } trig_mode_e;

    // True when the mode code asks for retriggerable behaviour.
    function automatic logic is_retrig(input logic [1:0] code);
        return code == TM_RETRIG;
    endfunction

endpackage

// File: rtl/bpg_trig_merge.sv
// Module: bpg_trig_merge
// Merges every start source into one trigger event per clock. The hardware
// source is decoded from a select code: 0 = own end-of-cycle, 1..NUM_PEERS =
// peer trigger g-1, anything higher = no hardware source. All inputs are
// assumed to be already in this clock domain.
module bpg_trig_merge #(
    parameter int NUM_PEERS = 4,
    parameter int SRC_W     = 4
) (
    input  logic [SRC_W-1:0]     start_src,
    input  logic [NUM_PEERS-1:0] peer_trig,
    input  logic                 self_eoc,
    input  logic                 sw_trig,
    input  logic                 sync_en,
    input  logic                 sync_pulse,
    output logic                 trig_event
);

    logic [NUM_PEERS-1:0] peer_hit;
    logic                 self_hit;

    // One decoder per peer: a peer counts only when its own code is selected.
    for (genvar g = 0; g < NUM_PEERS; g++) begin : g_peer
        assign peer_hit[g] = peer_trig[g] && (start_src == SRC_W'(g + 1));
    end

    // Self-trigger path for code 0.
    assign self_hit = self_eoc && (start_src == '0);

    // OR of all sources; simultaneous sources collapse into a single event.
    always_comb begin
        trig_event = sw_trig || (sync_en && sync_pulse) || self_hit || (|peer_hit);
    end

endmodule

// File: rtl/bpg_burst_seq.sv
// Module: bpg_burst_seq
// Burst sequencer: holds the running flag and the number of cycles still to
// run after the current one. Decides when a new cycle starts and when the
// burst stops. Assumes cycle_end is high only on the last clock of a cycle.
module bpg_burst_seq #(
    parameter int BURST_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               retrig,
    input  logic [BURST_W-1:0] burst_len,
    input  logic               trig_event,
    input  logic               cycle_end,
    output logic               active,
    output logic               start_cycle,
    output logic               stop_burst
);

    logic [BURST_W-1:0] remain_q;
    logic               trig_acc;

    // Accept a trigger when idle, or at any time in retriggerable mode.
    always_comb begin
        trig_acc    = trig_event && (!active || retrig);
        start_cycle = (!active && trig_acc) ||
                      (active && cycle_end && ((remain_q != '0) || trig_acc));
        stop_burst  = active && cycle_end && (remain_q == '0) && !trig_acc;
    end

    // Running flag and remaining-cycle count.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            active   <= 1'b0;
            remain_q <= '0;
        end else if (trig_acc) begin
            active   <= 1'b1;
            remain_q <= burst_len;
        end else if (stop_burst) begin
            active   <= 1'b0;
            remain_q <= '0;
        end else if (start_cycle) begin
            remain_q <= remain_q - 1'b1;
        end
    end

endmodule

// File: rtl/bpg_cycle_counter.sv
// Module: bpg_cycle_counter
// Period counter and duty comparator. Captures the period and duty at every
// cycle start, then counts 0..period-1. Assumes period_in is nonzero (the top
// module maps 0 to 1).
module bpg_cycle_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             active,
    input  logic             start_cycle,
    input  logic             stop_burst,
    input  logic [CNT_W-1:0] period_in,
    input  logic [CNT_W-1:0] duty_in,
    output logic             cycle_end,
    output logic             pwm
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] duty_q;

    // Counter with per-cycle capture of the period and duty.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt_q  <= '0;
            per_q  <= CNT_W'(1);
            duty_q <= '0;
        end else if (start_cycle) begin
            cnt_q  <= '0;
            per_q  <= period_in;
            duty_q <= duty_in;
        end else if (stop_burst) begin
            cnt_q  <= '0;
        end else if (active) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // End-of-cycle detect and edge-aligned compare, both gated by the burst.
    always_comb begin
        cycle_end = active && (cnt_q == per_q - CNT_W'(1));
        pwm       = active && (cnt_q < duty_q);
    end

endmodule

// File: rtl/burst_pwm_gen.sv
// Module: burst_pwm_gen (top)
// Edge-aligned PWM that runs bursts of burst_len+1 cycles on a start event.
// Selects the period and duty from local or master values, merges the start
// sources, and drives the waveform, the end-of-cycle pulse and the running
// status. Assumes every input is synchronous to clk.
module burst_pwm_gen
    import burst_pwm_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int NUM_PEERS = 4,
    parameter int SRC_W     = 4,
    parameter int BURST_W   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic [1:0]           trig_mode,
    input  logic [BURST_W-1:0]   burst_len,
    input  logic [SRC_W-1:0]     start_src,
    input  logic                 sync_en,
    input  logic                 use_master_per,
    input  logic                 use_master_duty,
    input  logic [CNT_W-1:0]     local_per,
    input  logic [CNT_W-1:0]     local_duty,
    input  logic [CNT_W-1:0]     master_per,
    input  logic [CNT_W-1:0]     master_duty,
    input  logic [NUM_PEERS-1:0] peer_trig,
    input  logic                 sw_trig,
    input  logic                 sync_pulse,
    output logic                 pwm_out,
    output logic                 eoc_pulse,
    output logic                 running
);

    localparam logic [CNT_W-1:0] MIN_PER = CNT_W'(1);

    logic             trig_event;
    logic             cycle_end;
    logic             active;
    logic             start_cycle;
    logic             stop_burst;
    logic             retrig;
    logic [CNT_W-1:0] per_raw;
    logic [CNT_W-1:0] per_eff;
    logic [CNT_W-1:0] duty_sel;

    // Source choice for period and duty; a zero period is raised to one.
    always_comb begin
        per_raw  = use_master_per  ? master_per  : local_per;
        duty_sel = use_master_duty ? master_duty : local_duty;
        per_eff  = (per_raw == '0) ? MIN_PER : per_raw;
        retrig   = is_retrig(trig_mode);
    end

    bpg_trig_merge #(
        .NUM_PEERS (NUM_PEERS),
        .SRC_W     (SRC_W)
    ) u_merge (
        .start_src  (start_src),
        .peer_trig  (peer_trig),
        .self_eoc   (cycle_end),
        .sw_trig    (sw_trig),
        .sync_en    (sync_en),
        .sync_pulse (sync_pulse),
        .trig_event (trig_event)
    );

    bpg_burst_seq #(
        .BURST_W (BURST_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .retrig      (retrig),
        .burst_len   (burst_len),
        .trig_event  (trig_event),
        .cycle_end   (cycle_end),
        .active      (active),
        .start_cycle (start_cycle),
        .stop_burst  (stop_burst)
    );

    bpg_cycle_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .active      (active),
        .start_cycle (start_cycle),
        .stop_burst  (stop_burst),
        .period_in   (per_eff),
        .duty_in     (duty_sel),
        .cycle_end   (cycle_end),
        .pwm         (pwm_out)
    );

    // Status outputs.
    assign eoc_pulse = cycle_end;
    assign running   = active;

endmodule

// File: rtl/burst_pwm_gen_checker.sv
// Module: burst_pwm_gen_checker
// Port-level temporal checks for burst_pwm_gen, attached with bind below.
module burst_pwm_gen_checker #(
    parameter int NUM_PEERS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 enable,
    input logic                 sw_trig,
    input logic                 sync_pulse,
    input logic [NUM_PEERS-1:0] peer_trig,
    input logic                 running,
    input logic                 pwm_out,
    input logic                 eoc_pulse
);

    // R1: an idle generator drives no waveform and no end-of-cycle pulse.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!pwm_out && !eoc_pulse));

    // R11: a low enable clears the burst at the next clock.
    p_disable_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !running);

    // R2: a software trigger always starts an enabled idle generator.
    p_sw_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !running && sw_trig) |=> running);

    // R2: with no trigger of any kind, an idle generator stays idle.
    p_idle_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !sw_trig && !sync_pulse && (peer_trig == '0)) |=> !running);

    // R4: a burst ends only on the last clock of a cycle.
    p_no_midcycle_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && running && !eoc_pulse) |=> running);

endmodule

bind burst_pwm_gen burst_pwm_gen_checker #(.NUM_PEERS(NUM_PEERS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .sw_trig    (sw_trig),
    .sync_pulse (sync_pulse),
    .peer_trig  (peer_trig),
    .running    (running),
    .pwm_out    (pwm_out),
    .eoc_pulse  (eoc_pulse)
);

// File: tb/burst_pwm_gen_tb.sv
// Directed bench for burst_pwm_gen: one task per scenario, each self-checking.
module burst_pwm_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [1:0]  trig_mode = 2'b00;
    logic [2:0]  burst_len = 3'd0;
    logic [3:0]  start_src = 4'd7;
    logic        sync_en = 1'b0;
    logic        use_master_per = 1'b0;
    logic        use_master_duty = 1'b0;
    logic [15:0] local_per = 16'd4;
    logic [15:0] local_duty = 16'd1;
    logic [15:0] master_per = 16'd4;
    logic [15:0] master_duty = 16'd1;
    logic [3:0]  peer_trig = 4'd0;
    logic        sw_trig = 1'b0;
    logic        sync_pulse = 1'b0;
    logic        pwm_out, eoc_pulse, running;

    int n_tests = 0;
    int n_fail  = 0;
    int rc, hc, ec;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_pwm_gen u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .trig_mode(trig_mode),
        .burst_len(burst_len), .start_src(start_src), .sync_en(sync_en),
        .use_master_per(use_master_per), .use_master_duty(use_master_duty),
        .local_per(local_per), .local_duty(local_duty),
        .master_per(master_per), .master_duty(master_duty),
        .peer_trig(peer_trig), .sw_trig(sw_trig), .sync_pulse(sync_pulse),
        .pwm_out(pwm_out), .eoc_pulse(eoc_pulse), .running(running)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Pulse the chosen sources for one clock, ending on a negedge.
    task automatic fire(input logic sw, input logic sy, input logic [3:0] pe);
        @(negedge clk);
        sw_trig = sw; sync_pulse = sy; peer_trig = pe;
        @(negedge clk);
        sw_trig = 0; sync_pulse = 0; peer_trig = 0;
    endtask

    // Count running, high and end-of-cycle clocks until the burst stops.
    task automatic measure(input int limit, input int trig_at, input int chg_at,
                           input int chg_val, output int r, output int h, output int e);
        r = 0; h = 0; e = 0;
        for (int i = 0; i < limit; i++) begin
            if (!running) break;
            r++;
            if (pwm_out) h++;
            if (eoc_pulse) e++;
            if (i == trig_at) sw_trig = 1;
            if (i == chg_at) local_per = 16'(chg_val);
            @(negedge clk);
            sw_trig = 0;
        end
    endtask

    task automatic setup(input int per, input int duty, input int n, input logic [1:0] mode);
        local_per = 16'(per); local_duty = 16'(duty);
        burst_len = 3'(n); trig_mode = mode;
        use_master_per = 0; use_master_duty = 0; start_src = 4'd7; sync_en = 0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 running after reset", running, 0);
        chk("R1 pwm after reset", pwm_out, 0);
        chk("R1 eoc after reset", eoc_pulse, 0);
    endtask

    task automatic t_basic_burst;
        setup(5, 2, 2, 2'b00);
        fire(1, 0, 0);
        measure(500, -1, -1, 0, rc, hc, ec);
        chk("R4 burst length", rc, 15);
        chk("R5 high clocks", hc, 6);
        chk("R6 eoc count", ec, 3);
        chk("R1 pwm idle after burst", pwm_out, 0);
    endtask

    task automatic t_len_bounds;
        setup(4, 1, 0, 2'b00);
        fire(1, 0, 0);
        measure(500, -1, -1, 0, rc, hc, ec);
        chk("R4 one-cycle burst", rc, 4);
        chk("R6 one-cycle eoc", ec, 1);
        setup(3, 2, 7, 2'b00);
        fire(1, 0, 0);
        measure(500, -1, -1, 0, rc, hc, ec);
        chk("R4 eight-cycle burst", rc, 24);
        chk("R5 eight-cycle highs", hc, 16);
        chk("R6 eight-cycle eoc", ec, 8);
    endtask

    task automatic t_duty_edges;
        setup(6, 0, 1, 2'b00);
        fire(1, 0, 0);
        measure(500, -1, -1, 0, rc, hc, ec);
        chk("R5 duty zero highs", hc, 0);
        chk("R4 duty zero length", rc, 12);
        setup(6, 9, 1, 2'b00);
        fire(1, 0, 0);
        measure(500, -1, -1, 0, rc, hc, ec);
        chk("R5 duty over period highs", hc, 12);
    endtask

    task automatic t_period_rules;
        setup(0, 1, 3, 2'b00);
        fire(1, 0, 0);
        measure(500, -1, -1, 0, rc, hc, ec);
        chk("R10 zero period length", rc, 4);
        chk("R10 zero period eoc", ec, 4);
        setup(4, 1, 1, 2'b00);
        fire(1, 0, 0);
        measure(500, -1, 1, 6, rc, hc, ec);
        chk("R10 midcycle period change", rc, 10);
        chk("R10 midcycle highs", hc, 2);
    endtask

    task automatic t_master_sel;
        setup(3, 1, 0, 2'b00);
        master_per = 16'd7; master_duty = 16'd3;
        use_master_per = 1; use_master_duty = 1;
        fire(1, 0, 0);
        measure(500, -1, -1, 0, rc, hc, ec);
        chk("R9 master period", rc, 7);
        chk("R9 master duty", hc, 3);
        use_master_per = 0;
        fire(1, 0, 0);
        measure(500, -1, -1, 0, rc, hc, ec);
        chk("R9 local period master duty", rc, 3);
        chk("R9 master duty clipped", hc, 3);
    endtask

    task automatic t_peer_sources;
        setup(3, 1, 0, 2'b00);
        for (int k = 1; k <= 4; k++) begin
            start_src = 4'(k);
            fire(0, 0, 4'(1 << ((k % 4))));
            chk("R2 unselected peer ignored", running, 0);
            fire(0, 0, 4'(1 << (k - 1)));
            chk("R2 selected peer starts", running, 1);
            measure(500, -1, -1, 0, rc, hc, ec);
        end
        start_src = 4'd9;
        fire(0, 0, 4'hF);
        chk("R2 no hardware source", running, 0);
        fire(1, 0, 0);
        chk("R2 software start", running, 1);
        measure(500, -1, -1, 0, rc, hc, ec);
    endtask

    task automatic t_sync;
        setup(3, 1, 0, 2'b00);
        fire(0, 1, 0);
        chk("R3 sync disabled", running, 0);
        sync_en = 1;
        fire(0, 1, 0);
        chk("R3 sync enabled", running, 1);
        measure(500, -1, -1, 0, rc, hc, ec);
        fire(1, 1, 4'hF);
        measure(500, -1, -1, 0, rc, hc, ec);
        chk("R12 merged trigger length", rc, 3);
        chk("R12 merged trigger eoc", ec, 1);
    endtask

    task automatic t_modes;
        setup(4, 1, 2, 2'b00);
        fire(1, 0, 0);
        measure(500, 9, -1, 0, rc, hc, ec);
        chk("R7 single ignores retrigger", rc, 12);
        setup(4, 1, 2, 2'b10);
        fire(1, 0, 0);
        measure(500, 9, -1, 0, rc, hc, ec);
        chk("R7 reserved code acts single", rc, 12);
        setup(4, 1, 2, 2'b01);
        fire(1, 0, 0);
        measure(500, 9, -1, 0, rc, hc, ec);
        chk("R8 retrigger extends burst", rc, 20);
        setup(3, 1, 1, 2'b00);
        start_src = 4'd0;
        fire(1, 0, 0);
        measure(500, -1, -1, 0, rc, hc, ec);
        chk("R7 self source single stops", rc, 6);
        setup(3, 1, 0, 2'b01);
        start_src = 4'd0;
        fire(1, 0, 0);
        measure(100, -1, -1, 0, rc, hc, ec);
        chk("R8 self retrigger continues", rc, 100);
        enable = 0;
        @(negedge clk);
        enable = 1;
    endtask

    task automatic t_disable;
        setup(8, 4, 3, 2'b00);
        fire(1, 0, 0);
        repeat (3) @(negedge clk);
        enable = 0;
        @(negedge clk);
        chk("R11 running cleared", running, 0);
        chk("R11 pwm cleared", pwm_out, 0);
        enable = 1;
        repeat (4) @(negedge clk);
        chk("R11 no resume", running, 0);
        fire(1, 0, 0);
        measure(500, -1, -1, 0, rc, hc, ec);
        chk("R11 fresh burst after enable", rc, 32);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1; enable = 1;
        t_reset();
        t_basic_burst();
        t_len_bounds();
        t_duty_edges();
        t_period_rules();
        t_master_sel();
        t_peer_sources();
        t_sync();
        t_modes();
        t_disable();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule